// File: doc/BRIEF.md
# Serial Converter Output Emulator

This block stands in for the digital side of a successive-approximation converter with a three-wire serial interface. A controller drives an active-low chip select and a serial clock. A parallel sample word plays the part of the converted analog value. The block answers on a serial data line, modelled as a data bit plus an output enable, so the bench can tell when the line is at high impedance.

A frame begins when chip select falls. At that point the sample word is frozen and the line starts driving a zero. Each later falling edge of the serial clock moves the line on by one bit. The line carries a fixed number of zero bits first, then the sample, most significant bit first. When the last bit of the frame has been consumed, the line releases by itself. It also releases at once if chip select rises early. The resolution and the number of leading zeros are parameters, and the frame length is their sum: 16 for 12 bits, 14 for 10 bits and 12 for 8 bits with four leading zeros.

Chip select and serial clock are sampled on the system clock `clk`, and edges are found by comparing each sample with the one before it. Every response appears one `clk` cycle after the edge that causes it.

Top module: `serial_conv_emu`

## Requirements
- R1: While `rst_n` is low, `sdata_oe` and `sdata` are both 0.
- R2: One `clk` cycle after `cs_n` is first sampled low following a high sample, `sdata_oe` is 1 and `sdata` is 0. The `sample_in` value seen in that cycle is captured. The sample taken before reset counts as high.
- R3: Changes on `sample_in` after the capture do not alter the bits of the running frame.
- R4: Bit positions 0 to `LEAD_ZEROS`-1 of a frame are 0. Position 0 is driven from the start, and position n follows the n-th serial clock falling edge.
- R5: Positions `LEAD_ZEROS` to FRAME-1 carry the captured word in straight binary, most significant bit first. FRAME equals `RES`+`LEAD_ZEROS`. Each position appears one `clk` cycle after the `sclk` falling edge that selects it.
- R6: While a frame is running, `sdata` and `sdata_oe` stay unchanged in any cycle without a serial clock falling edge, including cycles with a rising edge.
- R7: One `clk` cycle after the FRAME-th serial clock falling edge, `sdata_oe` returns to 0. Later falling edges leave it at 0 until the next chip-select fall.
- R8: When `cs_n` is sampled high, `sdata_oe` is 0 one `clk` cycle later, which aborts any frame in progress.
- R9: Serial clock falling edges while no frame runs do not enable the line.
- R10: Whenever `sdata_oe` is 0, `sdata` is 0.
- R11: When a chip-select fall and a serial clock fall are sampled in the same cycle, the frame starts at position 0 and the clock edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the controller |
| sclk | input | 1 | Serial clock from the controller |
| sample_in | input | RES | Parallel word standing in for the converted value |
| sdata | output | 1 | Serial data value |
| sdata_oe | output | 1 | 1 when the data line is driven, 0 for high impedance |

## Verification
Every response is due exactly one `clk` cycle after the edge that causes it: a chip-select fall, a chip-select high sample, or a serial-clock fall. The bench drives inputs on falling `clk` edges. A behavioural model updates on each rising edge, and the design is compared with it on the following falling edge, so the expected bit is settled before it is checked. Frame-level checks wait two cycles after each stimulus before reading the line, and they rebuild the expected bit stream directly from the requirement as zeros followed by the word.

// File: rtl/serial_conv_emu_pkg.sv
package serial_conv_emu_pkg;

    // Events decoded from the sampled control pins in one clk cycle
    typedef struct packed {
        logic cs_fall;   // chip select went from high to low
        logic cs_high;   // chip select currently deasserted
        logic sclk_fall; // serial clock went from high to low
    } sce_evt_t;

endpackage

// File: rtl/sce_edge_det.sv
module sce_edge_det #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
        fall   = prev_q & ~din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sce_frame_ctl.sv
module sce_frame_ctl
    import serial_conv_emu_pkg::*;
#(
    parameter int FRAME = 16,
    localparam int CW   = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sce_evt_t      evt,
    output logic          active,
    output logic [CW-1:0] pos
);
    typedef struct packed {
        logic          active;
        logic [CW-1:0] pos;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt.cs_high) begin
            st_d.active = 1'b0;
            st_d.pos    = '0;
        end else if (evt.cs_fall) begin
            st_d.active = 1'b1;
            st_d.pos    = '0;
        end else if (st_q.active && evt.sclk_fall) begin
            if (st_q.pos == CW'(FRAME - 1)) begin
                st_d.active = 1'b0;
                st_d.pos    = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign pos    = st_q.pos;
endmodule

// File: rtl/sce_out_shifter.sv
module sce_out_shifter
    import serial_conv_emu_pkg::*;
#(
    parameter int RES        = 12,
    parameter int LEAD_ZEROS = 4,
    localparam int FRAME     = RES + LEAD_ZEROS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  sce_evt_t       evt,
    input  logic           active,
    input  logic [RES-1:0] sample_in,
    output logic           msb
);
    logic [FRAME-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (evt.cs_fall && !evt.cs_high)
            sr_d = {{LEAD_ZEROS{1'b0}}, sample_in};
        else if (active && evt.sclk_fall)
            sr_d = {sr_q[FRAME-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb = sr_q[FRAME-1];
endmodule

// File: rtl/serial_conv_emu.sv
module serial_conv_emu
    import serial_conv_emu_pkg::*;
#(
    parameter int RES        = 12,
    parameter int LEAD_ZEROS = 4,
    localparam int FRAME     = RES + LEAD_ZEROS,
    localparam int CW        = $clog2(FRAME)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic [RES-1:0] sample_in,
    output logic           sdata,
    output logic           sdata_oe
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] pins;
    logic [NPINS-1:0] falls;
    sce_evt_t         evt;
    logic             active;
    logic [CW-1:0]    pos;
    logic             msb;

    assign pins = {sclk, cs_n};

    for (genvar g = 0; g < NPINS; g++) begin : g_edge
        sce_edge_det #(.IDLE(1'b1)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pins[g]),
            .fall (falls[g])
        );
    end

    always_comb begin
        evt.cs_fall   = falls[0];
        evt.cs_high   = cs_n;
        evt.sclk_fall = falls[1];
    end

    sce_frame_ctl #(.FRAME(FRAME)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .active(active),
        .pos   (pos)
    );

    sce_out_shifter #(.RES(RES), .LEAD_ZEROS(LEAD_ZEROS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .active   (active),
        .sample_in(sample_in),
        .msb      (msb)
    );

    assign sdata_oe = active;
    assign sdata    = active & msb;
endmodule

// File: rtl/serial_conv_emu_chk.sv
module serial_conv_emu_chk #(
    parameter int RES        = 12,
    parameter int LEAD_ZEROS = 4,
    localparam int FRAME     = RES + LEAD_ZEROS,
    localparam int KW        = $clog2(FRAME + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdata,
    input logic sdata_oe
);
    logic          c_csp, c_sp;
    logic [KW-1:0] c_cnt;
    logic          c_csf, c_sf;

    assign c_csf = c_csp & ~cs_n;
    assign c_sf  = c_sp & ~sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_csp <= 1'b1;
            c_sp  <= 1'b1;
            c_cnt <= '0;
        end else begin
            c_csp <= cs_n;
            c_sp  <= sclk;
            if (c_csf)
                c_cnt <= '0;
            else if (c_sf && c_cnt < KW'(FRAME))
                c_cnt <= c_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_reset_quiet_r1: assert (!sdata_oe && !sdata);
    end

    p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_csf |=> (sdata_oe && !sdata));

    p_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && c_cnt < KW'(LEAD_ZEROS)) |-> !sdata);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !c_csf && !c_sf) |=> ($stable(sdata) && $stable(sdata_oe)));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> (c_cnt < KW'(FRAME)));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdata_oe);

    p_stay_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdata_oe && !c_csf) |=> !sdata_oe);

    p_zero_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata);

    p_cs_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_csf && c_sf) |=> (sdata_oe && !sdata));
endmodule

bind serial_conv_emu serial_conv_emu_chk #(.RES(RES), .LEAD_ZEROS(LEAD_ZEROS)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sdata   (sdata),
    .sdata_oe(sdata_oe)
);

// File: tb/test_serial_conv_emu.sv
module test_serial_conv_emu;
    localparam int RES   = 12;
    localparam int LZ    = 4;
    localparam int FRAME = RES + LZ;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs_n = 1'b1;
    logic           sclk = 1'b1;
    logic [RES-1:0] sample_in = '0;
    logic           sdata, sdata_oe;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit             m_active;
    int             m_idx;
    logic [RES-1:0] m_word;
    bit             m_csp, m_sp;
    bit             exp_oe, exp_d;

    serial_conv_emu #(.RES(RES), .LEAD_ZEROS(LZ)) i_serial_conv_emu (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sample_in(sample_in),
        .sdata    (sdata),
        .sdata_oe (sdata_oe)
    );

    always #5 clk = ~clk;

    function automatic bit frame_bit(int idx, logic [RES-1:0] w);
        if (idx < LZ) return 1'b0;
        return w[RES-1-(idx-LZ)];
    endfunction

    always @(posedge clk) begin
        bit csf, sf;
        if (!rst_n) begin
            m_active = 0; m_idx = 0; m_word = '0; m_csp = 1; m_sp = 1;
        end else begin
            csf = m_csp && !cs_n;
            sf  = m_sp && !sclk;
            if (cs_n) m_active = 0;
            else if (csf) begin
                m_active = 1; m_idx = 0; m_word = sample_in;
            end else if (m_active && sf) begin
                m_idx++;
                if (m_idx == FRAME) m_active = 0;
            end
            m_csp = cs_n;
            m_sp  = sclk;
        end
        exp_oe = m_active;
        exp_d  = m_active ? frame_bit(m_idx, m_word) : 1'b0;
    end

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        check({cur_req, " oe"}, int'(sdata_oe), int'(exp_oe));
        check({cur_req, " data"}, int'(sdata), int'(exp_d));
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1; tick(2);
        sclk = 1'b0; tick(2);
    endtask

    // run a frame with nf falls; optionally scramble sample_in after capture
    task automatic run_frame(logic [RES-1:0] w, int nf, bit scramble);
        logic [FRAME-1:0] exp_bits;
        sample_in = w;
        cs_n = 1'b0;
        tick(2);
        check("R2 start oe", int'(sdata_oe), 1);
        check("R2 start zero", int'(sdata), 0);
        if (scramble) sample_in = ~w;
        exp_bits = {{LZ{1'b0}}, w};
        for (int i = 1; i <= nf; i++) begin
            sclk_pulse();
            if (i < FRAME) begin
                if (i < LZ) check("R4 lead zero", int'(sdata), 0);
                else if (scramble) check("R3 captured bit", int'(sdata), int'(exp_bits[FRAME-1-i]));
                else check("R5 data bit", int'(sdata), int'(exp_bits[FRAME-1-i]));
            end else begin
                check("R7 released", int'(sdata_oe), 0);
            end
        end
        cs_n = 1'b1;
        tick(2);
        check("R8 cs high releases", int'(sdata_oe), 0);
    endtask

    initial begin
        cur_req = "R1";
        tick(3);
        check("R1 reset oe", int'(sdata_oe), 0);
        check("R1 reset data", int'(sdata), 0);
        rst_n = 1'b1;
        tick(2);

        cur_req = "R5";
        run_frame(12'hA5C, FRAME, 0);
        run_frame(12'hFFF, FRAME, 0);
        run_frame(12'h000, FRAME, 0);
        run_frame(12'h801, FRAME, 0);

        cur_req = "R3";
        run_frame(12'h3C6, FRAME, 1);

        cur_req = "R7";
        run_frame(12'hFFF, FRAME + 3, 0);

        cur_req = "R8";
        run_frame(12'hFFF, 7, 0);

        cur_req = "R6";
        sample_in = 12'h9B4; cs_n = 1'b0; tick(2);
        sclk = 1'b1; tick(5);
        check("R6 rise no change", int'(sdata_oe), 1);
        sclk = 1'b0; tick(2);
        sclk = 1'b1; tick(2);
        check("R6 pos1 held", int'(sdata), 0);
        cs_n = 1'b1; tick(2);

        cur_req = "R9";
        for (int i = 0; i < 4; i++) sclk_pulse();
        check("R9 idle stays off", int'(sdata_oe), 0);

        cur_req = "R11";
        sclk = 1'b1; sample_in = 12'hFFF; tick(2);
        cs_n = 1'b0; sclk = 1'b0; tick(2);
        check("R11 coincident start", int'(sdata_oe), 1);
        check("R11 position zero", int'(sdata), 0);
        for (int i = 1; i <= LZ; i++) sclk_pulse();
        check("R11 first data bit", int'(sdata), 1);
        cs_n = 1'b1; tick(2);

        cur_req = "R10";
        tick(4);
        check("R10 off data zero", int'(sdata), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule